// File: doc/BRIEF.md
# Wrapping Pin-Span Mask Generator

This block takes one pin request and turns it into a bit operation on a contiguous group of I/O pins. The request gives a base pin number and a span that counts the extra pins after the base. The block builds a write-enable mask over a single 32-pin port register. It then updates that port's direction and output registers with one of four bit operations. The base pin's upper bit selects the port. The group wraps around inside that port and never spills into the other one, so a group that starts near the top of a port continues at the port's pin 0.

A separate count strobe can latch a pin count ahead of time. The next pin request then uses the latched count in place of its own span field. Only that one request uses it; after it the latch is empty again. Every result is registered: the mask, the port select and the new register contents appear one clock after the request strobe, and they hold while no request arrives.

Top module: `pin_span_unit`

## Requirements
- R1: A synchronous reset clears the direction and output registers of every port, the mask output and the port select output to zero.
- R2: A request with span n affects exactly n+1 pins. The mask is a run of n+1 ones starting at bit base[4:0] and going upward; with n = 31 the mask is all ones.
- R3: Pin positions in the run wrap modulo 32 inside the addressed port. Base 30 with span 3 gives mask 0xC0000003 (pins 30, 31, 0, 1).
- R4: Bit 5 of the base pin selects the port (0 = pins 0..31, 1 = pins 32..63) and drives port_sel. Only the selected port's registers may change.
- R5: A cnt_load strobe latches cnt_value as a pending count. The next request uses that count in place of req_span.
- R6: A pending count is used by one request only; the request after it uses req_span again. A cnt_load in the same cycle as a request does not apply to that request: it stays pending for the following request.
- R7: req_op encodings, applied to masked pins: 2'b00 sets direction to req_data; 2'b01 sets output to req_data; 2'b10 (float) clears direction and keeps output; 2'b11 (drive) sets direction to 1 and output to req_data.
- R8: Register bits outside the mask keep their values on every request.
- R9: Results appear one clock after the req_valid strobe. In a cycle without req_valid, the mask, port select and all port registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_load | input | 1 | Latch cnt_value as the pending count for the next request |
| cnt_value | input | 5 | Pin count that replaces the span field |
| req_valid | input | 1 | Request strobe |
| req_pin | input | 6 | Base pin; bit 5 selects the port |
| req_span | input | 5 | Extra pins after the base |
| req_op | input | 2 | Bit operation code |
| req_data | input | 1 | Data bit written by the operation |
| port_sel | output | 1 | Port addressed by the last request |
| span_mask | output | 32 | Mask of the last request |
| dir_q | output | 64 | Direction registers, port p at bits [32p+31:32p] |
| out_q | output | 64 | Output registers, port p at bits [32p+31:32p] |

## Verification
The assertions assume that reset is held over the first clock edges and that req_op always carries one of the four defined codes. They also assume that cnt_load and req_valid are plain one-cycle strobes sampled at the clock. The stimulus drives every input on the falling edge from the 2-bit and 5-bit fields it randomizes, so every op value is legal, and it keeps reset asserted for several cycles before the first request. Directed cases add the wrap at the top of each port, the full 32-pin span, and a count load that coincides with a request.

// File: rtl/pin_span_pkg.sv
package pin_span_pkg;

   // bit operation applied to the masked pins of one port
   typedef enum logic [1:0] {
      OP_DIR   = 2'b00,   // direction <- data
      OP_OUT   = 2'b01,   // output    <- data
      OP_FLOAT = 2'b10,   // direction <- 0
      OP_DRIVE = 2'b11    // direction <- 1, output <- data
   } pin_op_e;

   // mask construction variants
   localparam int MASK_ROTATE  = 0;
   localparam int MASK_PER_BIT = 1;

endpackage

// File: rtl/pin_span_count.sv
module pin_span_count #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             req,
   input  logic [CNT_W-1:0] field_span,
   output logic [CNT_W-1:0] eff_span
);

   logic             pending_q;
   logic [CNT_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
         held_q    <= '0;
      end else if (load) begin
         pending_q <= 1'b1;
         held_q    <= load_val;
      end else if (req) begin
         pending_q <= 1'b0;
      end
   end

   assign eff_span = pending_q ? held_q : field_span;

   // R6
   pending_consumed_chk: assert property (@(posedge clk) disable iff (rst)
      (req && !load) |=> (eff_span == field_span));

   // R5
   pending_latched_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> (eff_span == $past(load_val)));

endmodule

// File: rtl/pin_span_mask.sv
module pin_span_mask
   import pin_span_pkg::*;
#(
   parameter int PORT_W    = 32,
   parameter int MASK_IMPL = MASK_ROTATE,
   localparam int IDX_W    = $clog2(PORT_W)
) (
   input  logic [IDX_W-1:0]  base_idx,
   input  logic [IDX_W-1:0]  span,
   output logic [PORT_W-1:0] mask
);

   generate
      if (MASK_IMPL == MASK_ROTATE) begin : g_rotate
         logic [PORT_W-1:0]   thermo;
         logic [2*PORT_W-1:0] dbl;
         always_comb begin
            for (int i = 0; i < PORT_W; i++) begin
               thermo[i] = (i <= int'(span));
            end
         end
         assign dbl  = {thermo, thermo} << base_idx;
         assign mask = dbl[2*PORT_W-1:PORT_W];
      end else begin : g_per_bit
         always_comb begin
            for (int i = 0; i < PORT_W; i++) begin
               mask[i] = ((IDX_W'(i) - base_idx) <= span);
            end
         end
      end
   endgenerate

   always_comb begin
      // R2
      mask_count_chk: assert ($countones(mask) == int'(span) + 1);
      // R3
      mask_base_chk: assert (mask[base_idx]);
   end

endmodule

// File: rtl/pin_span_port.sv
module pin_span_port
   import pin_span_pkg::*;
#(
   parameter int PORT_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  pin_op_e           op,
   input  logic              data,
   input  logic [PORT_W-1:0] mask,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] out_q
);

   logic [PORT_W-1:0] dir_n;
   logic [PORT_W-1:0] out_n;
   logic [PORT_W-1:0] fill;

   assign fill = {PORT_W{data}};

   always_comb begin
      dir_n = dir_q;
      out_n = out_q;
      unique case (op)
         OP_DIR:   dir_n = (dir_q & ~mask) | (fill & mask);
         OP_OUT:   out_n = (out_q & ~mask) | (fill & mask);
         OP_FLOAT: dir_n = dir_q & ~mask;
         OP_DRIVE: begin
            dir_n = dir_q | mask;
            out_n = (out_q & ~mask) | (fill & mask);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= '0;
         out_q <= '0;
      end else if (wr_en) begin
         dir_q <= dir_n;
         out_q <= out_n;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (dir_q == '0 && out_q == '0));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ($stable(dir_q) && $stable(out_q)));

   // R8
   unmasked_keep_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((((dir_q ^ $past(dir_q)) | (out_q ^ $past(out_q))) & ~$past(mask)) == '0));

   // R7
   float_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && op == OP_FLOAT) |=> ((dir_q & $past(mask)) == '0 && $stable(out_q)));

   // R7
   drive_set_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && op == OP_DRIVE) |=>
         ((dir_q & $past(mask)) == $past(mask) &&
          (out_q & $past(mask)) == ({PORT_W{$past(data)}} & $past(mask))));

endmodule

// File: rtl/pin_span_unit.sv
module pin_span_unit
   import pin_span_pkg::*;
#(
   parameter int PORT_W    = 32,
   parameter int NUM_PORTS = 2,
   parameter int MASK_IMPL = MASK_ROTATE,
   localparam int IDX_W    = $clog2(PORT_W),
   localparam int SEL_W    = $clog2(NUM_PORTS),
   localparam int PIN_W    = IDX_W + SEL_W,
   localparam int ALL_W    = PORT_W * NUM_PORTS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cnt_load,
   input  logic [IDX_W-1:0]  cnt_value,
   input  logic              req_valid,
   input  logic [PIN_W-1:0]  req_pin,
   input  logic [IDX_W-1:0]  req_span,
   input  logic [1:0]        req_op,
   input  logic              req_data,
   output logic [SEL_W-1:0]  port_sel,
   output logic [PORT_W-1:0] span_mask,
   output logic [ALL_W-1:0]  dir_q,
   output logic [ALL_W-1:0]  out_q
);

   // elaboration-time parameter checks
   generate
      if (PORT_W < 2 || (PORT_W & (PORT_W - 1)) != 0) begin : g_bad_port_w
         $error("PORT_W must be a power of two of at least 2");
      end
      if (NUM_PORTS < 2 || (NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
         $error("NUM_PORTS must be a power of two of at least 2");
      end
      if (MASK_IMPL != MASK_ROTATE && MASK_IMPL != MASK_PER_BIT) begin : g_bad_impl
         $error("MASK_IMPL selects an unknown mask variant");
      end
   endgenerate

   logic [IDX_W-1:0]  eff_span;
   logic [PORT_W-1:0] mask_c;
   logic [SEL_W-1:0]  sel_c;
   pin_op_e           op_c;

   assign sel_c = req_pin[PIN_W-1:IDX_W];
   assign op_c  = pin_op_e'(req_op);

   pin_span_count #(.CNT_W(IDX_W)) u_count (
      .clk        (clk),
      .rst        (rst),
      .load       (cnt_load),
      .load_val   (cnt_value),
      .req        (req_valid),
      .field_span (req_span),
      .eff_span   (eff_span)
   );

   pin_span_mask #(.PORT_W(PORT_W), .MASK_IMPL(MASK_IMPL)) u_mask (
      .base_idx (req_pin[IDX_W-1:0]),
      .span     (eff_span),
      .mask     (mask_c)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         logic wr_en;
         assign wr_en = req_valid && (sel_c == SEL_W'(p));
         pin_span_port #(.PORT_W(PORT_W)) u_port (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .op    (op_c),
            .data  (req_data),
            .mask  (mask_c),
            .dir_q (dir_q[p*PORT_W +: PORT_W]),
            .out_q (out_q[p*PORT_W +: PORT_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         span_mask <= '0;
         port_sel  <= '0;
      end else if (req_valid) begin
         span_mask <= mask_c;
         port_sel  <= sel_c;
      end
   end

   // R9
   view_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> ($stable(span_mask) && $stable(port_sel)));

   // R4
   only_one_port_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> ($countones((dir_q ^ $past(dir_q)) | (out_q ^ $past(out_q))) <= PORT_W));

   // R1
   view_reset_chk: assert property (@(posedge clk)
      rst |=> (span_mask == '0 && port_sel == '0));

endmodule

// File: tb/tb_pin_span_unit.sv
`timescale 1ns/1ps
module tb_pin_span_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cnt_load = 1'b0;
   logic [4:0]  cnt_value = '0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_pin = '0;
   logic [4:0]  req_span = '0;
   logic [1:0]  req_op = '0;
   logic        req_data = 1'b0;
   logic [0:0]  port_sel, alt_sel;
   logic [31:0] span_mask, alt_mask;
   logic [63:0] dir_q, out_q, alt_dir, alt_out;

   always #5 clk = ~clk;

   pin_span_unit dut (
      .clk(clk), .rst(rst), .cnt_load(cnt_load), .cnt_value(cnt_value),
      .req_valid(req_valid), .req_pin(req_pin), .req_span(req_span),
      .req_op(req_op), .req_data(req_data), .port_sel(port_sel),
      .span_mask(span_mask), .dir_q(dir_q), .out_q(out_q));

   pin_span_unit #(.MASK_IMPL(1)) dut_alt (
      .clk(clk), .rst(rst), .cnt_load(cnt_load), .cnt_value(cnt_value),
      .req_valid(req_valid), .req_pin(req_pin), .req_span(req_span),
      .req_op(req_op), .req_data(req_data), .port_sel(alt_sel),
      .span_mask(alt_mask), .dir_q(alt_dir), .out_q(alt_out));

   int checks = 0;
   int errors = 0;

   // bench model
   logic [31:0] m_dir [2];
   logic [31:0] m_out [2];
   logic [31:0] m_mask = '0;
   logic        m_sel = 1'b0;
   logic        m_pend = 1'b0;
   logic [4:0]  m_cnt = '0;

   function automatic logic [31:0] ref_mask(input logic [4:0] base, input logic [4:0] n);
      logic [31:0] m = '0;
      for (int k = 0; k <= int'(n); k++) m[(int'(base) + k) % 32] = 1'b1;
      return m;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " mask"},    {32'd0, span_mask}, {32'd0, m_mask});
      chk({tag, " alt mask"},{32'd0, alt_mask},  {32'd0, m_mask});
      chk({tag, " sel"},     {63'd0, port_sel},  {63'd0, m_sel});
      chk({tag, " dir"},     dir_q, {m_dir[1], m_dir[0]});
      chk({tag, " out"},     out_q, {m_out[1], m_out[0]});
   endtask

   task automatic step(input logic v, input logic [5:0] pin, input logic [4:0] span,
                       input logic [1:0] op, input logic d, input logic ld,
                       input logic [4:0] lv, input string tag);
      logic [4:0]  n;
      logic [31:0] m;
      int          p;
      @(negedge clk);
      req_valid = v; req_pin = pin; req_span = span; req_op = op; req_data = d;
      cnt_load = ld; cnt_value = lv;
      if (v) begin
         n = m_pend ? m_cnt : span;
         m = ref_mask(pin[4:0], n);
         p = int'(pin[5]);
         case (op)
            2'b00: m_dir[p] = (m_dir[p] & ~m) | ({32{d}} & m);
            2'b01: m_out[p] = (m_out[p] & ~m) | ({32{d}} & m);
            2'b10: m_dir[p] = m_dir[p] & ~m;
            default: begin
               m_dir[p] = m_dir[p] | m;
               m_out[p] = (m_out[p] & ~m) | ({32{d}} & m);
            end
         endcase
         m_mask = m;
         m_sel  = pin[5];
      end
      if (ld) begin m_pend = 1'b1; m_cnt = lv; end
      else if (v) m_pend = 1'b0;
      @(posedge clk);
      #1;
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      m_dir[0] = '0; m_dir[1] = '0; m_out[0] = '0; m_out[1] = '0;
      // preload junk on inputs during reset
      req_valid = 1'b1; req_pin = 6'd7; req_span = 5'd4; req_op = 2'b11; req_data = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0; req_valid = 1'b0;
      #1;
      check_all("R1 reset state");

      // R3 wrap at the top of port A, drive low
      step(1, 6'd30, 5'd3, 2'b11, 1'b0, 0, 0, "R3 wrap port A drive low");
      chk("R3 exact mask", {32'd0, span_mask}, 64'h00000000_C0000003);
      // R4 same wrap in port B, port A untouched
      step(1, 6'd62, 5'd3, 2'b11, 1'b1, 0, 0, "R4 wrap port B");
      chk("R4 port B dir", {32'd0, dir_q[63:32]}, 64'h00000000_C0000003);
      // R2 full span
      step(1, 6'd5, 5'd31, 2'b01, 1'b1, 0, 0, "R2 full span output");
      chk("R2 all ones", {32'd0, span_mask}, 64'h00000000_FFFFFFFF);
      // R7 float on part of port B
      step(1, 6'd63, 5'd1, 2'b10, 1'b1, 0, 0, "R7 float");
      // R9 idle cycle with noisy inputs
      step(0, 6'd12, 5'd9, 2'b00, 1'b1, 0, 0, "R9 idle hold");
      // R5 pending count replaces span field
      step(0, 6'd0, 5'd0, 2'b00, 1'b0, 1, 5'd3, "R5 load count");
      step(1, 6'd0, 5'd0, 2'b00, 1'b1, 0, 0, "R5 override used");
      chk("R5 mask 0xF", {32'd0, span_mask}, 64'h00000000_0000000F);
      // R6 consumed: next request uses the field again
      step(1, 6'd40, 5'd0, 2'b01, 1'b0, 0, 0, "R6 override consumed");
      chk("R6 single pin", {32'd0, span_mask}, 64'h00000000_00000100);
      // R6 load coinciding with a request waits for the next one
      step(1, 6'd16, 5'd1, 2'b00, 1'b1, 1, 5'd7, "R6 concurrent load");
      chk("R6 concurrent mask", {32'd0, span_mask}, 64'h00000000_00030000);
      step(1, 6'd28, 5'd0, 2'b00, 1'b0, 0, 0, "R6 deferred count");
      chk("R6 deferred mask", {32'd0, span_mask}, 64'h00000000_0000000F | 64'h00000000_F0000000);
      // R8 random mix
      for (int it = 0; it < 600; it++) begin
         logic r_v, r_ld;
         r_v  = ($urandom % 4) != 0;
         r_ld = ($urandom % 5) == 0;
         step(r_v, 6'($urandom), 5'($urandom), 2'($urandom), 1'($urandom),
              r_ld, 5'($urandom), "R8 random");
      end
      // R1 reset after activity
      @(negedge clk);
      rst = 1'b1; req_valid = 1'b0; cnt_load = 1'b0;
      @(posedge clk); #1;
      m_dir[0] = '0; m_dir[1] = '0; m_out[0] = '0; m_out[1] = '0;
      m_mask = '0; m_sel = 1'b0; m_pend = 1'b0;
      check_all("R1 reset after use");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule